// File: doc/BRIEF.md
# Timed Multi-Factor Login Controller

This block is the sequencing state machine behind a login that asks for three independent proofs of identity. It collects a username and a password from a stream of received serial characters, with backspace editing. It keeps a masked copy of the password for display. It then waits for a contactless card to be presented and gathers a nine-digit ID number from remote-control keypresses. When all of that is in hand, it hands the collected material to an external credential checker and holds the verdict.

Each stage is guarded by an external loadable timer. The controller pulses `timer_load` whenever a stage begins. If `timer_expired` arrives while a stage is still waiting for input, the controller drops everything and returns to idle, so an abandoned session cannot be resumed by someone else. Prompt text, serial transmission, hashing and rendering live in neighbouring blocks. This block only issues the one-cycle requests (prompt starts, echo, bell, checker start) that drive them.

All pulse and level outputs are registered. The buffer contents are also held in registers. A response to an input sampled at a clock edge is therefore visible just after that same edge. Character `i` of every buffer sits at bits `[8*i+7 : 8*i]`.

Top module: `login_ctrl`

## Requirements
- R1: Escape (0x1B) received with `rx_valid` in any state, or `rst` high, returns the controller to idle. It refills every buffer with spaces (0x20) and sets all write positions to zero.
- R2: In idle, all inputs other than a received carriage return (0x0D) have no effect. A carriage return pulses `prompt_user` and `timer_load` for one cycle and starts username entry.
- R3: The username and password buffers hold 8 characters each and the ID buffer holds 9 characters. After reset every position reads 0x20, and character `i` occupies bits `[8*i+7:8*i]`.
- R4: Backspace (0x08) writes a space over the most recently stored character and moves the position back by one. A backspace at position 0 changes nothing and produces neither echo nor bell.
- R5: A character other than carriage return, backspace or escape that arrives while the active buffer is full is discarded. It raises `bell` for exactly one cycle and no echo.
- R6: Each accepted password character is stored unchanged in `pass_buf`, and 0x2A (asterisk) is stored at the same position of `pass_mask_buf`.
- R7: Each accepted username character raises `echo_valid` for one cycle with `echo_char` equal to that character. Each accepted password character does the same with `echo_char` = 0x2A.
- R8: A carriage return during username entry pulses `prompt_pass` and `timer_load` and starts password entry. A carriage return during password entry pulses `prompt_card` and `timer_load` and starts the card wait.
- R9: `timer_expired` during username, password, card-wait or ID-entry stages returns the controller to idle with all buffers refilled with spaces.
- R10: During the card wait, a `card_word` different from the idle value (default 0) pulses `tap_seen`, `prompt_id` and `timer_load` and starts ID entry. An idle-valued word changes nothing.
- R11: Each `ir_valid` digit code `d` during ID entry is stored as the byte {0011, d}.
- R12: Storing the ninth digit pulses `chk_start`. On `chk_done` the controller raises `authorised` if `chk_ok` is high, held until escape even across timer expiry. Otherwise it raises `unauthorised` and pulses `timer_load`, holding that until `timer_expired`, which returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received serial character strobe |
| rx_char | input | 8 | Received serial character |
| ir_valid | input | 1 | Remote-control digit strobe |
| ir_digit | input | 4 | Remote-control digit code |
| card_word | input | 32 | Card reader data word |
| timer_expired | input | 1 | Stage timer has run out |
| chk_done | input | 1 | Credential checker finished |
| chk_ok | input | 1 | Credential checker verdict, valid with chk_done |
| user_buf | output | 64 | Username characters |
| pass_buf | output | 64 | Password characters as typed |
| pass_mask_buf | output | 64 | Password shown as asterisks |
| id_buf | output | 72 | ID number as ASCII digits |
| prompt_user | output | 1 | Start username prompt (pulse) |
| prompt_pass | output | 1 | Start password prompt (pulse) |
| prompt_card | output | 1 | Start card prompt (pulse) |
| prompt_id | output | 1 | Start ID-number prompt (pulse) |
| timer_load | output | 1 | Reload the stage timer (pulse) |
| echo_valid | output | 1 | Echo request (pulse) |
| echo_char | output | 8 | Character to echo |
| bell | output | 1 | Buffer-full bell request (pulse) |
| tap_seen | output | 1 | Card tap detected (pulse) |
| chk_start | output | 1 | Start credential check (pulse) |
| authorised | output | 1 | Access granted (level) |
| unauthorised | output | 1 | Access refused (level) |

## Verification
A wrong write position shows up at once on the buffer ports. The next accepted character lands in the wrong byte lane, and the bell fires one character early or late. A lost stage shows in the very next response: a carriage return pulses the wrong prompt, echo arrives with a raw password character, or a card tap or timeout is ignored. Every such fault therefore appears one cycle after the input that exposes it. The bench sweeps every buffer position in both directions, both verdicts, and a timeout in each guarded stage.

// File: rtl/login_ctrl_pkg.sv
package login_ctrl_pkg;
   localparam logic [7:0] CH_ESC   = 8'h1B;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_BS    = 8'h08;
   localparam logic [7:0] CH_SPACE = 8'h20;
   localparam logic [7:0] CH_STAR  = 8'h2A;
   localparam logic [3:0] DIGIT_HI = 4'b0011;

   typedef enum logic [2:0] {
      ST_IDLE, ST_USER, ST_PASS, ST_CARD, ST_IDNUM, ST_CHECK, ST_GRANT, ST_DENY
   } stage_t;

   typedef struct packed {
      logic esc;
      logic cr;
      logic bs;
      logic plain;
   } char_class_t;
endpackage

// File: rtl/login_char_class.sv
module login_char_class
   import login_ctrl_pkg::*;
(
   input  logic        valid,
   input  logic [7:0]  ch,
   output char_class_t cls
);
   always_comb begin
      cls.esc   = valid && (ch == CH_ESC);
      cls.cr    = valid && (ch == CH_CR);
      cls.bs    = valid && (ch == CH_BS);
      cls.plain = valid && !(ch == CH_ESC || ch == CH_CR || ch == CH_BS);
   end
endmodule

// File: rtl/login_line_buffer.sv
module login_line_buffer #(
   parameter int unsigned     DEPTH   = 8,
   parameter int unsigned     CW      = 8,
   parameter bit              MASKED  = 1'b0,
   parameter logic [CW-1:0]   FILL    = 'h20,
   parameter logic [CW-1:0]   MASK_CH = 'h2A,
   localparam int unsigned    PW      = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr,
   input  logic                push,
   input  logic                pop,
   input  logic [CW-1:0]       din,
   output logic [DEPTH*CW-1:0] raw,
   output logic [DEPTH*CW-1:0] shown,
   output logic                full,
   output logic                last
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("login_line_buffer: DEPTH must be at least 1");
   end
   if (CW < 1) begin : g_bad_width
      $error("login_line_buffer: CW must be at least 1");
   end

   logic [PW-1:0] pos;

   assign full = (pos == PW'(DEPTH));
   assign last = (pos == PW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (rst || clr)               pos <= '0;
      else if (push && !full)       pos <= pos + 1'b1;
      else if (pop && pos != '0)    pos <= pos - 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [CW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (rst || clr)                                   slot_q <= FILL;
         else if (push && !full && pos == PW'(i))          slot_q <= din;
         else if (pop && !push && pos == PW'(i + 1))       slot_q <= FILL;
      end
      assign raw[i*CW +: CW] = slot_q;

      if (MASKED) begin : g_mask
         logic [CW-1:0] mask_q;
         always_ff @(posedge clk) begin
            if (rst || clr)                                mask_q <= FILL;
            else if (push && !full && pos == PW'(i))       mask_q <= MASK_CH;
            else if (pop && !push && pos == PW'(i + 1))    mask_q <= FILL;
         end
         assign shown[i*CW +: CW] = mask_q;
      end else begin : g_plain
         assign shown[i*CW +: CW] = slot_q;
      end
   end

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst) pos <= PW'(DEPTH)); // R3
   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R5
   AST_POP_STEP:  assert property (@(posedge clk) disable iff (rst)
                     (pop && !push && !clr && pos != '0) |=> pos == PW'($past(pos) - 1'b1)); // R4
   AST_POP_FLOOR: assert property (@(posedge clk) disable iff (rst)
                     (pop && !push && !clr && pos == '0) |=> pos == '0); // R4
   AST_CLEAR:     assert property (@(posedge clk) disable iff (rst) clr |=> pos == '0); // R1
endmodule

// File: rtl/login_ctrl.sv
module login_ctrl
   import login_ctrl_pkg::*;
#(
   parameter int unsigned         NAME_LEN  = 8,
   parameter int unsigned         ID_LEN    = 9,
   parameter int unsigned         DIGIT_W   = 4,
   parameter int unsigned         CARD_W    = 32,
   parameter logic [CARD_W-1:0]   CARD_IDLE = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  rx_valid,
   input  logic [7:0]            rx_char,
   input  logic                  ir_valid,
   input  logic [DIGIT_W-1:0]    ir_digit,
   input  logic [CARD_W-1:0]     card_word,
   input  logic                  timer_expired,
   input  logic                  chk_done,
   input  logic                  chk_ok,
   output logic [NAME_LEN*8-1:0] user_buf,
   output logic [NAME_LEN*8-1:0] pass_buf,
   output logic [NAME_LEN*8-1:0] pass_mask_buf,
   output logic [ID_LEN*8-1:0]   id_buf,
   output logic                  prompt_user,
   output logic                  prompt_pass,
   output logic                  prompt_card,
   output logic                  prompt_id,
   output logic                  timer_load,
   output logic                  echo_valid,
   output logic [7:0]            echo_char,
   output logic                  bell,
   output logic                  tap_seen,
   output logic                  chk_start,
   output logic                  authorised,
   output logic                  unauthorised
);
   if (NAME_LEN < 1 || ID_LEN < 1) begin : g_bad_len
      $error("login_ctrl: buffer lengths must be at least 1");
   end
   if (DIGIT_W != 4) begin : g_bad_digit
      $error("login_ctrl: digit codes must be 4 bits wide");
   end

   stage_t      state;
   char_class_t cls;
   logic        esc_hit, timeout_hit, wipe;
   logic        user_push, user_pop, user_full, user_last;
   logic        pass_push, pass_pop, pass_full, pass_last;
   logic        id_push, id_full, id_last;
   logic        bell_req;
   logic [NAME_LEN*8-1:0] user_raw_unused;
   logic [ID_LEN*8-1:0]   id_raw_unused;

   login_char_class i_class (.valid(rx_valid), .ch(rx_char), .cls(cls));

   always_comb begin
      esc_hit     = cls.esc;
      timeout_hit = timer_expired && (state == ST_USER || state == ST_PASS ||
                    state == ST_CARD || state == ST_IDNUM || state == ST_DENY);
      wipe        = esc_hit || timeout_hit;
      user_push   = !wipe && state == ST_USER  && cls.plain && !user_full;
      user_pop    = !wipe && state == ST_USER  && cls.bs;
      pass_push   = !wipe && state == ST_PASS  && cls.plain && !pass_full;
      pass_pop    = !wipe && state == ST_PASS  && cls.bs;
      id_push     = !wipe && state == ST_IDNUM && ir_valid && !id_full;
      bell_req    = !wipe && cls.plain &&
                    ((state == ST_USER && user_full) || (state == ST_PASS && pass_full));
   end

   login_line_buffer #(.DEPTH(NAME_LEN), .CW(8), .MASKED(1'b0), .FILL(CH_SPACE), .MASK_CH(CH_STAR))
      i_user (.clk(clk), .rst(rst), .clr(wipe), .push(user_push), .pop(user_pop),
              .din(rx_char), .raw(user_raw_unused), .shown(user_buf),
              .full(user_full), .last(user_last));

   login_line_buffer #(.DEPTH(NAME_LEN), .CW(8), .MASKED(1'b1), .FILL(CH_SPACE), .MASK_CH(CH_STAR))
      i_pass (.clk(clk), .rst(rst), .clr(wipe), .push(pass_push), .pop(pass_pop),
              .din(rx_char), .raw(pass_buf), .shown(pass_mask_buf),
              .full(pass_full), .last(pass_last));

   login_line_buffer #(.DEPTH(ID_LEN), .CW(8), .MASKED(1'b0), .FILL(CH_SPACE), .MASK_CH(CH_STAR))
      i_id (.clk(clk), .rst(rst), .clr(wipe), .push(id_push), .pop(1'b0),
            .din({DIGIT_HI, ir_digit}), .raw(id_raw_unused), .shown(id_buf),
            .full(id_full), .last(id_last));

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         prompt_user <= 1'b0;
         prompt_pass <= 1'b0;
         prompt_card <= 1'b0;
         prompt_id   <= 1'b0;
         timer_load  <= 1'b0;
         echo_valid  <= 1'b0;
         echo_char   <= '0;
         bell        <= 1'b0;
         tap_seen    <= 1'b0;
         chk_start   <= 1'b0;
      end else begin
         prompt_user <= 1'b0;
         prompt_pass <= 1'b0;
         prompt_card <= 1'b0;
         prompt_id   <= 1'b0;
         timer_load  <= 1'b0;
         echo_valid  <= 1'b0;
         tap_seen    <= 1'b0;
         chk_start   <= 1'b0;
         bell        <= bell_req;
         if (wipe) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: if (cls.cr) begin
                  state       <= ST_USER;
                  prompt_user <= 1'b1;
                  timer_load  <= 1'b1;
               end
               ST_USER: if (cls.cr) begin
                  state       <= ST_PASS;
                  prompt_pass <= 1'b1;
                  timer_load  <= 1'b1;
               end else if (user_push) begin
                  echo_valid  <= 1'b1;
                  echo_char   <= rx_char;
               end
               ST_PASS: if (cls.cr) begin
                  state       <= ST_CARD;
                  prompt_card <= 1'b1;
                  timer_load  <= 1'b1;
               end else if (pass_push) begin
                  echo_valid  <= 1'b1;
                  echo_char   <= CH_STAR;
               end
               ST_CARD: if (card_word != CARD_IDLE) begin
                  state       <= ST_IDNUM;
                  tap_seen    <= 1'b1;
                  prompt_id   <= 1'b1;
                  timer_load  <= 1'b1;
               end
               ST_IDNUM: if (id_push && id_last) begin
                  state       <= ST_CHECK;
                  chk_start   <= 1'b1;
               end
               ST_CHECK: if (chk_done) begin
                  state       <= chk_ok ? ST_GRANT : ST_DENY;
                  timer_load  <= !chk_ok;
               end
               ST_GRANT, ST_DENY: state <= state;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign authorised   = (state == ST_GRANT);
   assign unauthorised = (state == ST_DENY);

   AST_ESC_HOME:     assert property (@(posedge clk) disable iff (rst)
                        (rx_valid && rx_char == CH_ESC) |=> state == ST_IDLE); // R1
   AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (rst)
                        (state == ST_IDLE && !(rx_valid && rx_char == CH_CR)) |=> (state == ST_IDLE && !prompt_user)); // R2
   AST_ONE_PROMPT:   assert property (@(posedge clk) disable iff (rst)
                        $onehot0({prompt_user, prompt_pass, prompt_card, prompt_id})); // R8
   AST_BELL_NO_ECHO: assert property (@(posedge clk) disable iff (rst) bell |-> !echo_valid); // R5
   AST_TIMEOUT_HOME: assert property (@(posedge clk) disable iff (rst)
                        (timer_expired && (state == ST_USER || state == ST_PASS || state == ST_CARD || state == ST_IDNUM))
                        |=> (state == ST_IDLE && user_buf == {NAME_LEN{CH_SPACE}})); // R9
   AST_TAP_PROMPT:   assert property (@(posedge clk) disable iff (rst) tap_seen |-> (prompt_id && timer_load)); // R10
   AST_VERDICT:      assert property (@(posedge clk) disable iff (rst) !(authorised && unauthorised)); // R12
   AST_MASK_ECHO:    assert property (@(posedge clk) disable iff (rst)
                        (echo_valid && $past(state) == ST_PASS) |-> echo_char == CH_STAR); // R7
endmodule

// File: tb/test_login_ctrl.sv
module test_login_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_char = '0;
   logic        ir_valid = 1'b0;
   logic [3:0]  ir_digit = '0;
   logic [31:0] card_word = '0;
   logic        timer_expired = 1'b0;
   logic        chk_done = 1'b0;
   logic        chk_ok = 1'b0;
   logic [63:0] user_buf, pass_buf, pass_mask_buf;
   logic [71:0] id_buf;
   logic prompt_user, prompt_pass, prompt_card, prompt_id, timer_load;
   logic echo_valid, bell, tap_seen, chk_start, authorised, unauthorised;
   logic [7:0] echo_char;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   localparam logic [63:0] SP8 = {8{8'h20}};
   localparam logic [71:0] SP9 = {9{8'h20}};

   always #2 clk = ~clk;

   login_ctrl i_login_ctrl (.*);

   task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] c);
      rx_valid = 1'b1; rx_char = c; cycle(); rx_valid = 1'b0;
   endtask

   task automatic digit(input logic [3:0] d);
      ir_valid = 1'b1; ir_digit = d; cycle(); ir_valid = 1'b0;
   endtask

   task automatic expire();
      timer_expired = 1'b1; cycle(); timer_expired = 1'b0;
   endtask

   task automatic tap(input logic [31:0] w);
      card_word = w; cycle(); card_word = '0;
   endtask

   task automatic verdict(input logic ok);
      chk_done = 1'b1; chk_ok = ok; cycle(); chk_done = 1'b0;
   endtask

   task automatic all_blank(input string tag);
      check({tag, " user"}, user_buf, SP8);
      check({tag, " pass"}, pass_buf, SP8);
      check({tag, " mask"}, pass_mask_buf, SP8);
      check({tag, " id"}, id_buf, SP9);
   endtask

   initial begin
      logic [63:0] exp_u, exp_p, exp_m;
      logic [71:0] exp_id;
      repeat (3) cycle();
      rst = 1'b0;
      cycle();
      // R3 reset contents; R1 reset state
      all_blank("R3 reset");
      check("R1 reset verdicts", {authorised, unauthorised}, 0);

      // R2 idle ignores non-CR inputs
      send("a");
      check("R2 idle echo", {echo_valid, prompt_user, timer_load, bell}, 0);
      check("R2 idle user_buf", user_buf, SP8);
      tap(32'h1234);
      digit(4'd5);
      check("R2 idle tap/id", {tap_seen, prompt_id}, 0);
      check("R2 idle id_buf", id_buf, SP9);
      send(8'h0D);
      check("R2 CR prompt", {prompt_user, timer_load, prompt_pass}, 3'b110);

      // R7 and R3 fill username, each position in turn
      exp_u = SP8;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] c;
         c = 8'h61 + 8'(i);
         send(c);
         exp_u[i*8 +: 8] = c;
         check("R7 echo valid", {echo_valid, bell}, 2'b10);
         check("R7 echo char", echo_char, c);
         check("R3 user lane", user_buf, exp_u);
      end
      // R5 overflow
      send("z");
      check("R5 bell", {bell, echo_valid}, 2'b10);
      check("R5 not stored", user_buf, exp_u);
      cycle();
      check("R5 bell one cycle", bell, 0);
      // R4 backspace all the way down
      for (int i = 7; i >= 0; i--) begin
         send(8'h08);
         exp_u[i*8 +: 8] = 8'h20;
         check("R4 backspace", user_buf, exp_u);
      end
      send(8'h08);
      check("R4 backspace at 0", user_buf, SP8);
      check("R4 backspace at 0 quiet", {echo_valid, bell}, 0);
      send("k"); send("m");
      exp_u = SP8; exp_u[7:0] = "k"; exp_u[15:8] = "m";
      check("R4 refill after backspace", user_buf, exp_u);
      send(8'h0D);
      check("R8 user CR", {prompt_pass, timer_load, prompt_user, prompt_card}, 4'b1100);

      // R6 password with mask
      exp_p = SP8; exp_m = SP8;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] c;
         c = 8'h30 + 8'(i);
         send(c);
         exp_p[i*8 +: 8] = c;
         exp_m[i*8 +: 8] = 8'h2A;
         check("R6 raw", pass_buf, exp_p);
         check("R6 mask", pass_mask_buf, exp_m);
         check("R7 star echo", {echo_valid, echo_char}, {1'b1, 8'h2A});
      end
      send("q");
      check("R5 pass bell", {bell, echo_valid}, 2'b10);
      check("R5 pass unchanged", pass_buf, exp_p);
      send(8'h08);
      exp_p[63:56] = 8'h20; exp_m[63:56] = 8'h20;
      check("R4 pass backspace raw", pass_buf, exp_p);
      check("R4 pass backspace mask", pass_mask_buf, exp_m);
      check("R1 user kept", user_buf, exp_u);
      send(8'h0D);
      check("R8 pass CR", {prompt_card, timer_load, prompt_pass}, 3'b110);

      // R10 card wait
      cycle();
      check("R10 idle word no tap", {tap_seen, prompt_id}, 0);
      tap(32'h8000_0001);
      check("R10 tap", {tap_seen, prompt_id, timer_load}, 3'b111);

      // R11 digits, R12 check start on ninth
      exp_id = SP9;
      for (int i = 0; i < 9; i++) begin
         logic [3:0] d;
         d = 4'((i * 7) % 10);
         digit(d);
         exp_id[i*8 +: 8] = {4'b0011, d};
         check("R11 digit ascii", id_buf, exp_id);
         check("R12 chk_start", chk_start, (i == 8) ? 1 : 0);
      end
      verdict(1'b1);
      check("R12 authorised", {authorised, unauthorised}, 2'b10);
      expire();
      check("R12 grant survives timer", authorised, 1);
      send(8'h1B);
      check("R1 escape clears verdict", authorised, 0);
      all_blank("R1 escape");

      // R12 refusal path
      send(8'h0D); send(8'h0D); send(8'h0D);
      tap(32'h5);
      for (int i = 0; i < 9; i++) digit(4'(9 - i));
      verdict(1'b0);
      check("R12 unauthorised", {unauthorised, authorised, timer_load}, 3'b101);
      cycle();
      check("R12 deny held", unauthorised, 1);
      expire();
      check("R12 deny timeout", unauthorised, 0);
      all_blank("R12 deny reset");
      send("x");
      check("R12 back in idle", {echo_valid, prompt_user}, 0);

      // R9 timeout in each guarded stage
      for (int s = 0; s < 4; s++) begin
         send(8'h0D);
         send("u");
         if (s >= 1) begin send(8'h0D); send("p"); end
         if (s >= 2) send(8'h0D);
         if (s >= 3) begin tap(32'hA); digit(4'd3); end
         expire();
         all_blank("R9 timeout");
         send("x");
         check("R9 idle after timeout", {echo_valid, bell}, 0);
         tap(32'h7);
         check("R9 no tap after timeout", tap_seen, 0);
      end

      // R1 escape mid-username
      send(8'h0D); send("e"); send(8'h1B);
      check("R1 escape mid-user", user_buf, SP8);
      send("f");
      check("R1 idle after escape", echo_valid, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule